// File: doc/BRIEF.md
# Host-Loaded Synchronous Frame Transmitter

This block sits on the slave end of a clocked serial link. A host processor fills a 56-bit payload with four 16-bit writes: five user bytes followed by two check bytes. Each write goes to its own decoded address. Once all four write slots have been filled, the block puts a start byte in front of the payload and an end byte after it, which gives a 72-bit frame. The frame is then held until the link master asks for it.

The master asks by raising a request line and then dropping it. When the block sees the request fall, it waits a fixed number of link clocks. It then raises a gate line and shifts the frame out on a data line, one bit per clock, most significant bit first. The host may write the next payload while a frame is on the wire. Those writes land in the staging store and leave the frame being shifted unchanged.

Top module: `sync_frame_tx`

## Requirements
- R1: A sent frame is, most significant bit first, the byte 0x02, then slot 0 [15:0], slot 1 [15:0], slot 2 [15:0], slot 3 [15:8], then the byte 0x03. That is 72 bits in total.
- R2: A write is accepted only when `wr_en` is high and `wr_addr[4]` is 1. `wr_addr[3:0]` goes through a 4-to-16 decoder, and only the decoded values 0 to 3 select slots 0 to 3. Any other write changes no slot and does not count toward a complete payload.
- R3: On a write to slot 3, only `wr_data[15:8]` is stored. `wr_data[7:0]` has no effect on the frame.
- R4: A request fall starts a frame only if all four slots have been written since the last frame started. Otherwise nothing is sent and `gate_o` stays low.
- R5: Call edge k the clock edge that samples `req` low after sampling it high on the edge before. If that fall starts a frame, `gate_o` goes high right after edge k+10 (GAP_CLKS = 10).
- R6: `gate_o` stays high for exactly 72 consecutive clocks. One frame bit is presented on `data_o` per clock, and both outputs change only on the rising clock edge.
- R7: After reset, and whenever no frame is being shifted, `gate_o` and `data_o` are both low.
- R8: Host writes made after a frame has started do not change that frame. A payload of four fresh writes made during a transmission becomes the next frame.
- R9: A request fall that arrives during the wait or during shifting is ignored. It does not start a further frame.
- R10: Starting a frame uses up the payload. A later request with no new writes sends nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 5 | Bit 4 enables the decoder; bits 3:0 give the decoded select |
| wr_data | input | 16 | Host write data |
| req | input | 1 | Request from the link master; its falling edge triggers a send |
| gate_o | output | 1 | High while frame bits are valid on `data_o` |
| data_o | output | 1 | Serial frame data, MSB first |

## Verification
The hardest situation to reach is one where a full replacement payload and a second request fall both arrive while a frame is already on the wire. In that case the frame in flight must stay intact, the second fall must be ignored, and the new payload must wait for a later request. The stimulus gets there by starting a send and, part way through the 72 data clocks, issuing four writes to all slots followed by a request pulse. It then watches that the current frame matches the old payload, that no gate appears afterwards until a new request is made, and that the next frame carries the new payload. Partial loads, stray addresses and a changed low half in slot 3 are each checked by looking at the serial frame, or at the absence of one.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int BYTE_W    = 8;
  localparam int HOST_W    = 16;
  localparam int SLOTS     = 4;
  localparam int DEC_W     = 4;
  localparam int DEC_N     = 1 << DEC_W;
  localparam int PAY_BYTES = 7;
  localparam int PAY_W     = PAY_BYTES * BYTE_W;
  localparam int FRAME_W   = PAY_W + 2 * BYTE_W;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GAP  = 2'd1,
    SEQ_SEND = 2'd2
  } seq_state_t;

  // Full 4-to-16 decode with enable, reduced to the slot strobes.
  function automatic logic [SLOTS-1:0] slot_hits(input logic en,
                                                 input logic [DEC_W-1:0] sel);
    logic [DEC_N-1:0] onehot;
    onehot = '0;
    if (en) onehot[sel] = 1'b1;
    return onehot[SLOTS-1:0];
  endfunction

  // Wrap the payload with the start and end markers.
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [BYTE_W-1:0] head,
                                                    input logic [PAY_W-1:0]  body,
                                                    input logic [BYTE_W-1:0] tail);
    return {head, body, tail};
  endfunction
endpackage

// File: rtl/sft_host_load.sv
module sft_host_load
  import sft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DEC_W:0]    wr_addr,
  input  logic [HOST_W-1:0] wr_data,
  input  logic              take,
  output logic [PAY_W-1:0]  payload,
  output logic              full
);
  logic [SLOTS-1:0] hit;
  logic [SLOTS-1:0] seen_q;

  assign hit = slot_hits(wr_en & wr_addr[DEC_W], wr_addr[DEC_W-1:0]);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int HI = PAY_W - 1 - HOST_W * s;
    localparam int W  = (HI + 1 >= HOST_W) ? HOST_W : HI + 1;
    logic [W-1:0] part_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      part_q <= '0;
      else if (hit[s]) part_q <= wr_data[HOST_W-1 -: W];
    end
    assign payload[HI -: W] = part_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= (take ? '0 : seen_q) | hit;
  end

  assign full = &seen_q;
endmodule

// File: rtl/sft_sequencer.sv
module sft_sequencer
  import sft_pkg::*;
#(
  parameter int GAP_CLKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic full,
  output logic launch,
  output logic start_tx,
  output logic shift_en
);
  localparam int GW = $clog2(GAP_CLKS + 1);
  localparam int BW = $clog2(FRAME_W + 1);

  seq_state_t    st_q;
  logic          req_q;
  logic [GW-1:0] gap_q;
  logic [BW-1:0] bit_q;
  logic          req_fall;

  assign req_fall = req_q & ~req;
  assign launch   = (st_q == SEQ_IDLE) & req_fall & full;
  assign start_tx = (st_q == SEQ_GAP) & (gap_q == GW'(GAP_CLKS - 1));
  assign shift_en = (st_q == SEQ_SEND) & (bit_q < BW'(FRAME_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      st_q  <= SEQ_IDLE;
      gap_q <= '0;
      bit_q <= '0;
    end else begin
      req_q <= req;
      unique case (st_q)
        SEQ_IDLE: if (launch) begin
          st_q  <= SEQ_GAP;
          gap_q <= '0;
        end
        SEQ_GAP: if (start_tx) begin
          st_q  <= SEQ_SEND;
          bit_q <= BW'(1);
        end else begin
          gap_q <= gap_q + 1'b1;
        end
        SEQ_SEND: if (shift_en) begin
          bit_q <= bit_q + 1'b1;
        end else begin
          st_q <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter
  import sft_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               advance,
  output logic               gate_o,
  output logic               data_o
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      gate_o <= 1'b0;
      data_o <= 1'b0;
    end else begin
      if (load) begin
        sh_q <= frame;
      end else if (advance) begin
        sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
      end
      gate_o <= advance;
      data_o <= advance & sh_q[FRAME_W-1];
    end
  end
endmodule

// File: rtl/sync_frame_tx.sv
module sync_frame_tx
  import sft_pkg::*;
#(
  parameter int             GAP_CLKS = 10,
  parameter logic [7:0]     SOF_BYTE = 8'h02,
  parameter logic [7:0]     EOF_BYTE = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        req,
  output logic        gate_o,
  output logic        data_o
);
  logic               launch_w;
  logic               start_w;
  logic               shift_w;
  logic               full_w;
  logic [PAY_W-1:0]   payload_w;
  logic [FRAME_W-1:0] frame_w;

  sft_host_load u_load (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .take    (launch_w),
    .payload (payload_w),
    .full    (full_w)
  );

  assign frame_w = pack_frame(SOF_BYTE, payload_w, EOF_BYTE);

  sft_sequencer #(.GAP_CLKS(GAP_CLKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .full     (full_w),
    .launch   (launch_w),
    .start_tx (start_w),
    .shift_en (shift_w)
  );

  sft_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch_w),
    .frame   (frame_w),
    .advance (start_w | shift_w),
    .gate_o  (gate_o),
    .data_o  (data_o)
  );
endmodule

// File: rtl/sft_checker.sv
module sft_checker
  import sft_pkg::*;
#(
  parameter int GAP_CLKS = 10
) (
  input logic clk,
  input logic rst_n,
  input logic gate_o,
  input logic data_o,
  input logic launch,
  input logic full
);
  logic [15:0] since_launch;
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_launch <= 16'hFFFF;
      run          <= '0;
    end else begin
      if (launch)                    since_launch <= 16'd1;
      else if (since_launch != 16'hFFFF) since_launch <= since_launch + 1'b1;
      run <= gate_o ? run + 1'b1 : '0;
    end
  end

  // R5
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> since_launch == 16'(GAP_CLKS + 1));

  // R6
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> run == 16'(FRAME_W));

  // R6
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> run < 16'(FRAME_W));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_o |-> !data_o);

  // R1
  sof_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && run == 16'd6) |-> data_o);

  // R1
  eof_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && run >= 16'(FRAME_W - 2)) |-> data_o);

  // R10
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !full);
endmodule

bind sync_frame_tx sft_checker #(.GAP_CLKS(GAP_CLKS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .gate_o (gate_o),
  .data_o (data_o),
  .launch (launch_w),
  .full   (full_w)
);

// File: tb/tb_sync_frame_tx.sv
module tb_sync_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        req = 1'b0;
  logic        gate_o;
  logic        data_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sync_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .req(req), .gate_o(gate_o), .data_o(data_o)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [71:0] ref_frame(input logic [15:0] a, b, c, d);
    return {8'h02, a, b, c, d[15:8], 8'h03};
  endfunction

  task automatic host_wr(input logic [4:0] adr, input logic [15:0] dat);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = adr; wr_data = dat;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all(input logic [15:0] a, b, c, d);
    host_wr(5'h10, a); host_wr(5'h11, b); host_wr(5'h12, c); host_wr(5'h13, d);
  endtask

  // Issues a request pulse (optional) and follows the link for one frame time.
  task automatic run_tx(input bit issue_req, input bit expect_tx,
                        input logic [71:0] exp, input bit mid_load,
                        input logic [15:0] n0, n1, n2, n3,
                        input bit mid_req, input string rq);
    logic [71:0] rx;
    int gap_bad, width_bad, idle_bad, highs;
    rx = '0; gap_bad = 0; width_bad = 0; idle_bad = 0; highs = 0;
    if (issue_req) begin
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
    end
    for (int j = 0; j < 120; j++) begin
      @(negedge clk);
      if (gate_o) highs++;
      if (expect_tx) begin
        if (j < 10 && (gate_o || data_o)) gap_bad++;
        if (j >= 10 && j < 82) begin
          if (!gate_o) width_bad++;
          rx = {rx[70:0], data_o};
        end
        if (j >= 82 && (gate_o || data_o)) idle_bad++;
      end
      if (mid_load) begin
        if (j >= 30 && j < 34) begin
          wr_en = 1'b1; wr_addr = {1'b1, 4'(j - 30)};
          wr_data = (j == 30) ? n0 : (j == 31) ? n1 : (j == 32) ? n2 : n3;
        end else if (j == 34) wr_en = 1'b0;
      end
      if (mid_req) begin
        if (j == 40) req = 1'b1;
        if (j == 41) req = 1'b0;
      end
    end
    if (expect_tx) begin
      chk(gap_bad == 0, "R5", {rq, " gate low during 10-clock gap"}, 72'(gap_bad), 72'd0);
      chk(width_bad == 0 && highs == 72, "R6", {rq, " gate width 72"}, 72'(highs), 72'd72);
      chk(rx == exp, "R1", {rq, " frame content"}, rx, exp);
      chk(idle_bad == 0, "R7", {rq, " outputs low after frame"}, 72'(idle_bad), 72'd0);
    end else begin
      chk(highs == 0, rq, "no gate expected", 72'(highs), 72'd0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gate_o == 1'b0, "R7", "gate low after reset", 72'(gate_o), 72'd0);
    chk(data_o == 1'b0, "R7", "data low after reset", 72'(data_o), 72'd0);
  endtask

  task automatic t_empty_and_partial();
    run_tx(1, 0, '0, 0, '0, '0, '0, '0, 0, "R4");
    host_wr(5'h10, 16'hA55A); host_wr(5'h11, 16'h0F0F); host_wr(5'h12, 16'hC3C3);
    run_tx(1, 0, '0, 0, '0, '0, '0, '0, 0, "R4");
    host_wr(5'h13, 16'h81E7);
    run_tx(1, 1, ref_frame(16'hA55A, 16'h0F0F, 16'hC3C3, 16'h81E7), 0,
           '0, '0, '0, '0, 0, "R4 completed load");
  endtask

  task automatic t_consume();
    run_tx(1, 0, '0, 0, '0, '0, '0, '0, 0, "R10");
  endtask

  task automatic t_stray_writes();
    // Three good slots, slot 3 only through disabled or out-of-range addresses.
    host_wr(5'h10, 16'h1357); host_wr(5'h11, 16'h2468); host_wr(5'h12, 16'hFEDC);
    host_wr(5'h03, 16'hBA98);
    host_wr(5'h15, 16'h7777);
    run_tx(1, 0, '0, 0, '0, '0, '0, '0, 0, "R2");
    // Complete it, then hit slot 0 through disabled and out-of-range addresses.
    host_wr(5'h13, 16'h6C00);
    host_wr(5'h00, 16'hDEAD);
    host_wr(5'h1F, 16'hBEEF);
    run_tx(1, 1, ref_frame(16'h1357, 16'h2468, 16'hFEDC, 16'h6C00), 0,
           '0, '0, '0, '0, 0, "R2 stray writes");
  endtask

  task automatic t_low_half();
    load_all(16'h0001, 16'h8000, 16'h5A5A, 16'h4200);
    host_wr(5'h13, 16'h42FF);
    run_tx(1, 1, ref_frame(16'h0001, 16'h8000, 16'h5A5A, 16'h4200), 0,
           '0, '0, '0, '0, 0, "R3 slot3 low half");
  endtask

  task automatic t_shadow();
    load_all(16'h9ABC, 16'h0123, 16'h4567, 16'hEF00);
    run_tx(1, 1, ref_frame(16'h9ABC, 16'h0123, 16'h4567, 16'hEF00), 1,
           16'hFFFF, 16'h0000, 16'hAAAA, 16'h55CC, 1, "R8 frame in flight");
    run_tx(0, 0, '0, 0, '0, '0, '0, '0, 0, "R9");
    run_tx(1, 1, ref_frame(16'hFFFF, 16'h0000, 16'hAAAA, 16'h55CC), 0,
           '0, '0, '0, '0, 0, "R8 shadow payload");
  endtask

  initial begin
    t_reset();
    t_empty_and_partial();
    t_consume();
    t_stray_writes();
    t_low_half();
    t_shadow();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule